// File: doc/BRIEF.md
# Dual-Role SPI Byte Shifter

This block moves 8-bit frames over a four-wire SPI link and can act either as the bus master or as a bus slave, chosen by one mode input. As master it generates the serial clock from an 8-bit divider, holding the clock at the polarity level while idle and running exactly eight clock periods for each byte. As slave it takes the serial clock and an active-low select from the pins. Both inputs pass through two-flop synchronizers, and a byte exchange starts when the select goes low.

A register block on the parallel side hands over one transmit byte at a time with a write strobe, and sees whether that byte is still pending. It receives each completed byte together with a one-cycle done strobe. Clock polarity and clock phase choose which serial clock edge launches data and which edge samples it. The same rules apply in both roles.

Top module: `spi_shift_engine`

## Requirements
- R1: After reset the outputs are low (`sclk_o`, `sdo`, `rx_done`, `tx_full`), and the divider holds 27, so the first master byte runs at 56 system clocks per serial clock period.
- R2: In master mode each serial clock period lasts 2 × (1 + divider) system clocks. A write strobe on `div_we` loads a new divider value.
- R3: While the master is idle, `sclk_o` equals `cpol`. Each byte gives exactly eight leading edges, and the clock stops at the `cpol` level when no byte is pending.
- R4: Bits go out and come in most-significant first. With `sdo` looped back to `sdi`, the master receives the byte it sent, for all four polarity and phase settings.
- R5: Leading edge means the clock moves away from the `cpol` level. With `cpha`=0 the first bit is on `sdo` before the first leading edge, data is sampled on leading edges, and it changes on trailing edges. With `cpha`=1 data changes on leading edges and is sampled on trailing edges.
- R6: If a new byte is pending when the eighth period ends, the master goes straight on into the next byte without a pause in the clock.
- R7: In slave mode `sclk_oe` is low. A byte exchange begins when `csn_i` is driven low. The slave returns the pending transmit byte (all zeros if none is pending) and delivers the byte received on `sdi`.
- R8: In slave mode, while `csn_i` stays low, bytes keep being exchanged back to back, each completed byte raising its own done strobe.
- R9: If `csn_i` goes high in the middle of a byte, the partial byte is dropped with no done strobe, and the next select starts a fresh byte.
- R10: A transmit write while `tx_full` is high is ignored, and the byte already held is the one sent.
- R11: `rx_done` is a single-cycle pulse, and `rx_data` holds the completed byte in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | system clock |
| rst | input | 1 | synchronous reset, active high |
| master_en | input | 1 | 1 = master role, 0 = slave role |
| cpol | input | 1 | idle level of the serial clock |
| cpha | input | 1 | 0 = sample on leading edge, 1 = sample on trailing edge |
| div_we | input | 1 | divider write strobe |
| div_wdata | input | 8 | new divider value |
| tx_we | input | 1 | transmit byte write strobe |
| tx_wdata | input | 8 | transmit byte |
| tx_full | output | 1 | a transmit byte is pending |
| rx_data | output | 8 | last received byte |
| rx_done | output | 1 | one-cycle strobe marking a completed byte |
| sclk_o | output | 1 | serial clock driven in master role |
| sclk_oe | output | 1 | output enable for the serial clock pin |
| sclk_i | input | 1 | serial clock from the pin in slave role |
| csn_i | input | 1 | active-low select in slave role |
| sdi | input | 1 | serial data in |
| sdo | output | 1 | serial data out |

## Verification
A bit counter that is off by one leaves every later byte shifted by a bit in `rx_data`, and this shows at the first done strobe. A divider or toggle counter that goes wrong shows as a lead-to-lead interval on `sclk_o` that differs from 2 × (1 + divider) within one period, or as a ninth edge or a missing edge when a byte ends. A select abort that does not clear state gives either an extra done strobe or a misaligned byte on the very next frame. An edge-selection fault gives captured `sdo` bits that differ from the loaded byte in the first frame of that mode.

// File: rtl/spi_eng_pkg.sv
package spi_eng_pkg;
  // serial clock events, one system clock wide
  typedef struct packed {
    logic lead;   // clock leaves its idle level
    logic trail;  // clock returns to its idle level
  } sclk_evt_t;
endpackage

// File: rtl/spi_master_clk.sv
module spi_master_clk
  import spi_eng_pkg::*;
#(
  parameter int DIVW  = 8,
  parameter int FRAME = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            en,
  input  logic            cpol,
  input  logic [DIVW-1:0] div,
  input  logic            pend,
  output logic            sclk,
  output logic            busy,
  output logic            begin_p,
  output sclk_evt_t       evt
);
  localparam int EDGES = 2 * FRAME;
  localparam int TW    = $clog2(EDGES);

  logic [DIVW-1:0] cnt;
  logic [TW-1:0]   tog;
  logic            tick;
  logic            last_tog;

  assign tick      = busy && (cnt == div);
  assign last_tog  = (tog == TW'(EDGES - 1));
  assign evt.lead  = tick && !tog[0];
  assign evt.trail = tick && tog[0];
  assign begin_p   = en && !busy && pend;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      cnt  <= '0;
      tog  <= '0;
      sclk <= 1'b0;
    end else if (!en) begin
      busy <= 1'b0;
      cnt  <= '0;
      tog  <= '0;
      sclk <= cpol;
    end else if (!busy) begin
      sclk <= cpol;
      cnt  <= '0;
      tog  <= '0;
      if (pend) busy <= 1'b1;
    end else if (tick) begin
      cnt  <= '0;
      sclk <= ~sclk;
      tog  <= last_tog ? '0 : tog + 1'b1;
      if (last_tog && !pend) busy <= 1'b0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  // R3: idle clock sits at the polarity level
  a_r3_idle_level: assert property (@(posedge clk) disable iff (rst)
    (en && !busy && $past(en) && $past(!busy) && $stable(cpol)) |-> (sclk == cpol));
endmodule

// File: rtl/spi_slave_front.sv
module spi_slave_front
  import spi_eng_pkg::*;
#(
  parameter int SYNC = 2
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      en,
  input  logic      cpol,
  input  logic      sclk_i,
  input  logic      csn_i,
  input  logic      sdi_i,
  output sclk_evt_t evt,
  output logic      cs_act,
  output logic      cs_start,
  output logic      sdi_s
);
  logic [SYNC-1:0] sck_q, cs_q, sd_q;
  logic            sck_prev, cs_prev;
  logic            sck_s, cs_s, moved;

  generate
    if (SYNC > 1) begin : g_chain
      always_ff @(posedge clk) begin
        if (rst) begin
          sck_q <= '0;
          cs_q  <= '1;
          sd_q  <= '0;
        end else begin
          sck_q <= {sck_q[SYNC-2:0], sclk_i};
          cs_q  <= {cs_q[SYNC-2:0], csn_i};
          sd_q  <= {sd_q[SYNC-2:0], sdi_i};
        end
      end
    end else begin : g_single
      always_ff @(posedge clk) begin
        if (rst) begin
          sck_q <= '0;
          cs_q  <= '1;
          sd_q  <= '0;
        end else begin
          sck_q <= sclk_i;
          cs_q  <= csn_i;
          sd_q  <= sdi_i;
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      sck_prev <= 1'b0;
      cs_prev  <= 1'b1;
    end else begin
      sck_prev <= sck_s;
      cs_prev  <= cs_s;
    end
  end

  assign sck_s     = sck_q[SYNC-1];
  assign cs_s      = cs_q[SYNC-1];
  assign sdi_s     = sd_q[SYNC-1];
  assign moved     = (sck_s != sck_prev);
  assign cs_act    = en && !cs_s;
  assign cs_start  = en && !cs_s && cs_prev;
  assign evt.lead  = cs_act && !cs_start && moved && (sck_s != cpol);
  assign evt.trail = cs_act && !cs_start && moved && (sck_s == cpol);
endmodule

// File: rtl/spi_shifter.sv
module spi_shifter
  import spi_eng_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         active,
  input  logic         start,
  input  logic         cpha,
  input  sclk_evt_t    evt,
  input  logic         sdi,
  input  logic [W-1:0] load_data,
  input  logic         load_ok,
  output logic         sdo,
  output logic         take,
  output logic [W-1:0] rx_data,
  output logic         done
);
  localparam int CW = (W > 2) ? $clog2(W) : 1;

  logic [W-1:0]  sr, rx_sr, nxt;
  logic [CW-1:0] bcnt;
  logic          smp, lnc, boundary, load_now;

  assign smp      = cpha ? evt.trail : evt.lead;
  assign lnc      = cpha ? evt.lead  : evt.trail;
  assign boundary = (bcnt == '0);
  assign load_now = (start && !cpha) || (active && !start && lnc && boundary);
  assign take     = load_now && load_ok;
  assign nxt      = load_ok ? load_data : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      sr      <= '0;
      rx_sr   <= '0;
      bcnt    <= '0;
      sdo     <= 1'b0;
      rx_data <= '0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start) begin
        bcnt <= '0;
        if (!cpha) {sdo, sr} <= {nxt, 1'b0};
      end else if (!active) begin
        bcnt <= '0;
      end else begin
        if (lnc) begin
          if (boundary) {sdo, sr} <= {nxt, 1'b0};
          else          {sdo, sr} <= {sr, 1'b0};
        end
        if (smp) begin
          rx_sr <= {rx_sr[W-2:0], sdi};
          if (bcnt == CW'(W - 1)) begin
            bcnt    <= '0;
            done    <= 1'b1;
            rx_data <= {rx_sr[W-2:0], sdi};
          end else begin
            bcnt <= bcnt + 1'b1;
          end
        end
      end
    end
  end

  // R11: done never lasts two cycles
  a_r11_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  // R9: no completion outside a frame window
  a_r9_no_done_idle: assert property (@(posedge clk) disable iff (rst)
    (!active && !start) |=> !done);
endmodule

// File: rtl/spi_shift_engine.sv
module spi_shift_engine
  import spi_eng_pkg::*;
#(
  parameter int            W       = 8,
  parameter int            DIVW    = 8,
  parameter logic [DIVW-1:0] DIV_RST = DIVW'(27),
  parameter int            SYNC    = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            master_en,
  input  logic            cpol,
  input  logic            cpha,
  input  logic            div_we,
  input  logic [DIVW-1:0] div_wdata,
  input  logic            tx_we,
  input  logic [W-1:0]    tx_wdata,
  output logic            tx_full,
  output logic [W-1:0]    rx_data,
  output logic            rx_done,
  output logic            sclk_o,
  output logic            sclk_oe,
  input  logic            sclk_i,
  input  logic            csn_i,
  input  logic            sdi,
  output logic            sdo
);
  logic [DIVW-1:0] div_r;
  logic [W-1:0]    tx_hold;
  logic            take;
  logic            m_busy, m_begin;
  sclk_evt_t       m_evt, s_evt, evt;
  logic            s_act, s_start, s_sdi;
  logic            active, start, sdi_sel;

  always_ff @(posedge clk) begin
    if (rst) begin
      div_r   <= DIV_RST;
      tx_hold <= '0;
      tx_full <= 1'b0;
      sclk_oe <= 1'b0;
    end else begin
      sclk_oe <= master_en;
      if (div_we) div_r <= div_wdata;
      if (take) begin
        tx_full <= 1'b0;
      end else if (tx_we && !tx_full) begin
        tx_hold <= tx_wdata;
        tx_full <= 1'b1;
      end
    end
  end

  spi_master_clk #(.DIVW(DIVW), .FRAME(W)) u_mclk (
    .clk(clk), .rst(rst), .en(master_en), .cpol(cpol), .div(div_r),
    .pend(tx_full), .sclk(sclk_o), .busy(m_busy), .begin_p(m_begin),
    .evt(m_evt)
  );

  spi_slave_front #(.SYNC(SYNC)) u_sfront (
    .clk(clk), .rst(rst), .en(!master_en), .cpol(cpol), .sclk_i(sclk_i),
    .csn_i(csn_i), .sdi_i(sdi), .evt(s_evt), .cs_act(s_act),
    .cs_start(s_start), .sdi_s(s_sdi)
  );

  assign active  = master_en ? m_busy  : s_act;
  assign start   = master_en ? m_begin : s_start;
  assign evt     = master_en ? m_evt   : s_evt;
  assign sdi_sel = master_en ? sdi     : s_sdi;

  spi_shifter #(.W(W)) u_shift (
    .clk(clk), .rst(rst), .active(active), .start(start), .cpha(cpha),
    .evt(evt), .sdi(sdi_sel), .load_data(tx_hold), .load_ok(tx_full),
    .sdo(sdo), .take(take), .rx_data(rx_data), .done(rx_done)
  );

  // R10: a write into a full holding register changes nothing
  a_r10_full_keeps: assert property (@(posedge clk) disable iff (rst)
    (tx_full && tx_we && !take) |=> (tx_full && tx_hold == $past(tx_hold)));
  // R7: the slave role never drives the clock pin
  a_r7_slave_no_drive: assert property (@(posedge clk) disable iff (rst)
    (!master_en && $past(!master_en)) |-> !sclk_oe);
endmodule

// File: tb/spi_shift_engine_test.sv
module spi_shift_engine_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       master_en = 1'b1, cpol = 1'b0, cpha = 1'b0;
  logic       div_we = 1'b0, tx_we = 1'b0;
  logic [7:0] div_wdata = '0, tx_wdata = '0;
  logic       tx_full, rx_done, sclk_o, sclk_oe, sdo, sdi;
  logic [7:0] rx_data;
  logic       sclk_i = 1'b0, csn_i = 1'b1, sdi_drv = 1'b0;

  always #2.5 clk = ~clk;
  assign sdi = master_en ? sdo : sdi_drv;

  spi_shift_engine uut (
    .clk(clk), .rst(rst), .master_en(master_en), .cpol(cpol), .cpha(cpha),
    .div_we(div_we), .div_wdata(div_wdata), .tx_we(tx_we), .tx_wdata(tx_wdata),
    .tx_full(tx_full), .rx_data(rx_data), .rx_done(rx_done), .sclk_o(sclk_o),
    .sclk_oe(sclk_oe), .sclk_i(sclk_i), .csn_i(csn_i), .sdi(sdi), .sdo(sdo)
  );

  int checks = 0, fails = 0, cyc = 0;
  int mdiv = 27;
  int lead_count = 0, done_count = 0, last_lead = 0, last_int = 0;
  bit mon_en = 0, burst_new = 1, prev_done = 0, finished = 0;
  logic sck_prev = 1'b0;
  logic [7:0] cap = '0;
  int capn = 0;
  logic [7:0] exp_tx[$];
  logic [7:0] exp_rx[$];
  localparam int H = 10;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(posedge clk) cyc <= cyc + 1;

  // monitor: serial clock edges in master role and received bytes
  always @(negedge clk) begin
    if (!rst && mon_en && master_en && sclk_o != sck_prev) begin
      if (sclk_o != cpol) begin
        lead_count++;
        if (!burst_new) begin
          last_int = cyc - last_lead;
          chk(last_int == 2 * (mdiv + 1), "R2 lead interval", last_int, 2 * (mdiv + 1));
        end else if (last_lead != 0 || lead_count > 0) begin
          last_int = 0;
        end
        burst_new = 0;
        last_lead = cyc;
      end
      if ((sclk_o != cpol) == !cpha) begin
        cap = {cap[6:0], sdo};
        capn++;
        if (capn == 8) begin
          capn = 0;
          if (exp_tx.size() == 0) chk(0, "R5 unexpected byte on sdo", cap, 0);
          else begin
            logic [7:0] e;
            e = exp_tx.pop_front();
            chk(cap == e, "R5 sdo at sampling edge", cap, e);
          end
        end
      end
    end
    sck_prev = sclk_o;
    if (!rst && rx_done) begin
      done_count++;
      chk(!prev_done, "R11 single-cycle done", 1, 0);
      if (exp_rx.size() == 0) chk(0, "R4 unexpected rx byte", rx_data, 0);
      else begin
        logic [7:0] e;
        e = exp_rx.pop_front();
        chk(rx_data == e, master_en ? "R4 master rx" : "R8 slave rx", rx_data, e);
      end
    end
    prev_done = rx_done;
  end

  task automatic cfg(input bit pol, input bit pha);
    @(negedge clk);
    mon_en = 0;
    cpol = pol;
    cpha = pha;
    repeat (4) @(negedge clk);
    capn = 0;
    mon_en = 1;
  endtask

  task automatic set_div(input int v);
    @(negedge clk);
    div_we = 1; div_wdata = 8'(v);
    @(negedge clk);
    div_we = 0;
    mdiv = v;
  endtask

  task automatic write_tx(input logic [7:0] b);
    tx_wdata = b; tx_we = 1;
    @(negedge clk);
    tx_we = 0;
  endtask

  task automatic master_xfer(input logic [7:0] bs[$]);
    int l0, tgt;
    l0 = lead_count;
    tgt = done_count + bs.size();
    burst_new = 1;
    foreach (bs[i]) begin
      while (tx_full) @(negedge clk);
      exp_tx.push_back(bs[i]);
      exp_rx.push_back(bs[i]);
      write_tx(bs[i]);
    end
    wait (done_count == tgt);
    repeat (4 * (mdiv + 1) + 4) @(negedge clk);
    chk(sclk_o == cpol, "R3 idle level after burst", sclk_o, cpol);
    chk(lead_count - l0 == 8 * bs.size(), "R3 edges per burst", lead_count - l0, 8 * bs.size());
  endtask

  task automatic slave_xfer(input logic [7:0] mo[$], input logic [7:0] mi[$], input bit preload);
    logic [7:0] c;
    int n;
    n = mo.size();
    sclk_i = cpol; csn_i = 1;
    @(negedge clk);
    if (!preload) write_tx(mi[0]);
    foreach (mo[k]) exp_rx.push_back(mo[k]);
    csn_i = 0;
    if (!cpha) sdi_drv = mo[0][7];
    repeat (H) @(negedge clk);
    for (int k = 0; k < n; k++) begin
      c = '0;
      for (int i = 0; i < 8; i++) begin
        if (cpha) sdi_drv = mo[k][7-i];
        if (!cpha) c = {c[6:0], sdo};
        sclk_i = ~cpol;
        if (i == 3 && k + 1 < n) begin
          @(negedge clk);
          write_tx(mi[k+1]);
          repeat (H - 2) @(negedge clk);
        end else repeat (H) @(negedge clk);
        if (cpha) c = {c[6:0], sdo};
        sclk_i = cpol;
        if (!cpha) begin
          if (i < 7) sdi_drv = mo[k][6-i];
          else if (k + 1 < n) sdi_drv = mo[k+1][7];
        end
        repeat (H) @(negedge clk);
      end
      chk(c == mi[k], k == 0 ? "R7 slave sdo byte" : "R8 slave sdo next byte", c, mi[k]);
    end
    csn_i = 1;
    repeat (2 * H) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(sclk_o == 0, "R1 sclk_o reset", sclk_o, 0);
    chk(sdo == 0, "R1 sdo reset", sdo, 0);
    chk(rx_done == 0, "R1 rx_done reset", rx_done, 0);
    chk(tx_full == 0, "R1 tx_full reset", tx_full, 0);
    rst = 0;
    repeat (3) @(negedge clk);
    chk(sclk_oe == 1, "R2 master drives clock", sclk_oe, 1);
    mon_en = 1;
    // default divider
    master_xfer('{8'hA5});
    chk(last_int == 56, "R1 default divider period", last_int, 56);
    set_div(3);
    cfg(0, 1);
    master_xfer('{8'h3C});
    // back to back at the fastest rate
    set_div(0);
    cfg(1, 0);
    master_xfer('{8'h81, 8'h7E});
    chk(last_int == 2, "R6 no gap between bytes", last_int, 2);
    set_div(5);
    cfg(1, 1);
    master_xfer('{8'h5A});
    chk(exp_tx.size() == 0 && exp_rx.size() == 0, "R4 all master bytes seen", exp_rx.size(), 0);
    // slave role
    mon_en = 0;
    master_en = 0;
    cfg(0, 0);
    mon_en = 0;
    repeat (3) @(negedge clk);
    chk(sclk_oe == 0, "R7 slave leaves clock undriven", sclk_oe, 0);
    slave_xfer('{8'hC6, 8'h1B}, '{8'h9D, 8'h42}, 0);
    cfg(1, 1);
    mon_en = 0;
    slave_xfer('{8'hE1}, '{8'h07}, 0);
    // abort mid-byte (R9)
    cfg(0, 0);
    mon_en = 0;
    begin
      int d0;
      d0 = done_count;
      sclk_i = 0; csn_i = 0; sdi_drv = 1;
      repeat (H) @(negedge clk);
      for (int i = 0; i < 4; i++) begin
        sclk_i = 1; repeat (H) @(negedge clk);
        sclk_i = 0; repeat (H) @(negedge clk);
      end
      csn_i = 1;
      repeat (4 * H) @(negedge clk);
      chk(done_count == d0, "R9 no done on aborted byte", done_count, d0);
    end
    slave_xfer('{8'h96}, '{8'h69}, 0);
    // write while full is dropped (R10)
    write_tx(8'h3C);
    write_tx(8'hC3);
    chk(tx_full == 1, "R10 held byte still pending", tx_full, 1);
    slave_xfer('{8'h55}, '{8'h3C}, 1);
    chk(tx_full == 0, "R10 held byte consumed", tx_full, 0);
    repeat (10) @(negedge clk);
    chk(exp_rx.size() == 0, "R8 all slave bytes received", exp_rx.size(), 0);
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule